// File: doc/BRIEF.md
# Masked Control Register Bank

This block is a bank of 32-bit control registers on a simple single-cycle bus made of a byte address, a write strobe, write data, a read strobe and read data. The writable registers take a bit-enable pattern with every write. The upper half of the write word says which bits of the lower half may change, so a write that was issued by mistake, or that reaches the wrong register, cannot change fields it did not explicitly enable. Only bits that are both enabled and written take the new data.

The address space is split into three regions, chosen by the address bits above `RGN_SHIFT`. Region 0 holds pin-function selectors: each register carries two 7-bit selectors, and each selector has its own group of enable bits. Region 1 holds output-invert controls, sixteen pins per register. Region 2 is a read-only status window onto an external input vector, thirty-two pins per register, which is sampled on every clock. All stored selectors and invert bits also drive parallel outputs, so other logic on the chip can use them directly.

With the default parameters there are 8 function selectors at byte addresses 0x000 to 0x00C, 32 invert pins at 0x100 and 0x104, and 64 status pins at 0x200 and 0x204.

Top module: `masked_ctrl_bank`

## Requirements
- R1: In a writable register, bit k of the lower half (k from 0 to 15) takes wr_data[k] only when wr_data[k+16] is set in the same write. Every other stored bit keeps its value.
- R2: A write whose bits 31:16 are all zero changes no stored bit and no output.
- R3: Function selector f sits in region 0 at word f/2, which is byte offset (f/2)*4. An even f uses data bits 6:0, enabled by bits 22:16. An odd f uses data bits 14:8, enabled by bits 30:24.
- R4: A read of a function register returns the even selector in bits 6:0 and the odd selector in bits 14:8. Bits 7, 15 and 31:16 read as zero, because the enable pattern is never stored.
- R5: Invert pin n sits in region 1 at word n/16, bit n%16, and appears on inv_o[n]. A read returns the pins in bits 15:0 and zero in bits 31:16.
- R6: A read of status word w in region 2 returns stat_i[w*32 +: 32] as it was sampled at the previous clock edge. Status pin n is bit n%32 of word n/32.
- R7: A write to the status region changes no stored bit and no output.
- R8: An active-low synchronous reset clears all selectors, all invert bits and rd_data to zero.
- R9: rd_data shows the addressed register one cycle after rd_en, with the value from before any write in that same cycle. While rd_en is low, rd_data holds its last value.
- R10: Addresses outside the three regions, or past the last word of a region, read as zero, and writes to them change nothing.
- R11: func_sel_o[f*7 +: 7] always equals the stored value of function selector f.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address |
| wr_data | input | 32 | Write data: bits 31:16 are the enables, bits 15:0 the value |
| rd_data | output | 32 | Registered read data |
| stat_i | input | NUM_STAT | External status vector |
| func_sel_o | output | NUM_FUNC*7 | Packed function selectors |
| inv_o | output | NUM_INV | Output-invert controls |

## Verification
Some properties are checked by the assertions on every cycle. Bits whose enable was clear never change. Writes with an all-zero enable half, writes to the status region and writes to unmapped addresses leave the outputs untouched. rd_data holds while no read is in progress, and the unused read bits of the masked regions stay at zero. Other behaviour can only be shown by the bench's scenarios: that an enabled bit takes exactly the written value, how function numbers and pin numbers map onto words and bit positions, the one-cycle lag of the status sample, and the read-before-write order within a cycle. The bench shows these by comparing every read and every output against its own model, under both random and directed traffic.

// File: rtl/mcb_pkg.sv
package mcb_pkg;
   localparam int unsigned BUS_W   = 32;
   localparam int unsigned HALF_W  = 16;
   localparam int unsigned FIELD_W = 7;
   localparam int unsigned HI_LSB  = 8;

   typedef enum logic [1:0] {
      RGN_FUNC = 2'd0,
      RGN_INV  = 2'd1,
      RGN_STAT = 2'd2,
      RGN_NONE = 2'd3
   } region_e;

   // Bit-enabled merge of a 7-bit selector
   function automatic logic [FIELD_W-1:0] field_merge(
      input logic [FIELD_W-1:0] cur,
      input logic [FIELD_W-1:0] val,
      input logic [FIELD_W-1:0] en);
      return (cur & ~en) | (val & en);
   endfunction
endpackage

// File: rtl/mcb_addr_dec.sv
module mcb_addr_dec
   import mcb_pkg::*;
#(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned RGN_SHIFT  = 8,
   parameter int unsigned FUNC_WORDS = 4,
   parameter int unsigned INV_WORDS  = 2,
   parameter int unsigned STAT_WORDS = 2,
   localparam int unsigned IDX_W     = RGN_SHIFT - 2,
   localparam int unsigned SEL_W     = ADDR_W - RGN_SHIFT
) (
   input  logic [ADDR_W-1:0] addr_i,
   output region_e           rgn_o,
   output logic [IDX_W-1:0]  idx_o
);
   localparam logic [IDX_W:0] FUNC_LIM = (IDX_W+1)'(FUNC_WORDS);
   localparam logic [IDX_W:0] INV_LIM  = (IDX_W+1)'(INV_WORDS);
   localparam logic [IDX_W:0] STAT_LIM = (IDX_W+1)'(STAT_WORDS);

   logic [SEL_W-1:0] sel;
   logic [1:0]       unused_lsb;

   assign sel        = addr_i[ADDR_W-1:RGN_SHIFT];
   assign idx_o      = addr_i[RGN_SHIFT-1:2];
   assign unused_lsb = addr_i[1:0];

   always_comb begin
      rgn_o = RGN_NONE;
      if (sel == SEL_W'(0) && {1'b0, idx_o} < FUNC_LIM)
         rgn_o = RGN_FUNC;
      else if (sel == SEL_W'(1) && {1'b0, idx_o} < INV_LIM)
         rgn_o = RGN_INV;
      else if (sel == SEL_W'(2) && {1'b0, idx_o} < STAT_LIM)
         rgn_o = RGN_STAT;
   end
endmodule

// File: rtl/mcb_func_bank.sv
module mcb_func_bank
   import mcb_pkg::*;
#(
   parameter int unsigned NUM_FUNC = 8,
   parameter int unsigned IDX_W    = 6,
   localparam int unsigned FLAT_W  = NUM_FUNC * FIELD_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [BUS_W-1:0] wdata_i,
   output logic [FLAT_W-1:0] fields_o,
   output logic [BUS_W-1:0] rword_o
);
   logic [FLAT_W-1:0] fields_q;
   logic              unused_gap;

   assign unused_gap = ^{wdata_i[31], wdata_i[23], wdata_i[15], wdata_i[7]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fields_q <= '0;
      end else if (wr_i) begin
         for (int f = 0; f < int'(NUM_FUNC); f++) begin
            if (idx_i == IDX_W'(f / 2)) begin
               fields_q[f*FIELD_W +: FIELD_W] <= field_merge(
                  fields_q[f*FIELD_W +: FIELD_W],
                  wdata_i[(f % 2)*HI_LSB +: FIELD_W],
                  wdata_i[HALF_W + (f % 2)*HI_LSB +: FIELD_W]);
            end
         end
      end
   end

   always_comb begin
      rword_o = '0;
      for (int f = 0; f < int'(NUM_FUNC); f++) begin
         if (idx_i == IDX_W'(f / 2))
            rword_o[(f % 2)*HI_LSB +: FIELD_W] = fields_q[f*FIELD_W +: FIELD_W];
      end
   end

   assign fields_o = fields_q;
endmodule

// File: rtl/mcb_mask_bank.sv
module mcb_mask_bank
   import mcb_pkg::*;
#(
   parameter int unsigned NUM_BITS  = 32,
   parameter int unsigned IDX_W     = 6,
   localparam int unsigned NUM_WORDS = NUM_BITS / HALF_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_i,
   input  logic [IDX_W-1:0]    idx_i,
   input  logic [BUS_W-1:0]    wdata_i,
   output logic [NUM_BITS-1:0] bits_o,
   output logic [BUS_W-1:0]    rword_o
);
   logic [NUM_BITS-1:0] bits_q;
   logic [HALF_W-1:0]   en;
   logic [HALF_W-1:0]   val;

   assign en  = wdata_i[BUS_W-1:HALF_W];
   assign val = wdata_i[HALF_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bits_q <= '0;
      end else if (wr_i) begin
         for (int w = 0; w < int'(NUM_WORDS); w++) begin
            if (idx_i == IDX_W'(w))
               bits_q[w*HALF_W +: HALF_W] <= (bits_q[w*HALF_W +: HALF_W] & ~en) | (val & en);
         end
      end
   end

   always_comb begin
      rword_o = '0;
      for (int w = 0; w < int'(NUM_WORDS); w++) begin
         if (idx_i == IDX_W'(w))
            rword_o[HALF_W-1:0] = bits_q[w*HALF_W +: HALF_W];
      end
   end

   assign bits_o = bits_q;
endmodule

// File: rtl/mcb_stat_bank.sv
module mcb_stat_bank
   import mcb_pkg::*;
#(
   parameter int unsigned NUM_BITS   = 64,
   parameter bit          SAMPLE_REG = 1'b1,
   parameter int unsigned IDX_W      = 6,
   localparam int unsigned NUM_WORDS = NUM_BITS / BUS_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_BITS-1:0] stat_i,
   input  logic [IDX_W-1:0]    idx_i,
   output logic [BUS_W-1:0]    rword_o
);
   logic [NUM_BITS-1:0] stat_q;

   generate
      if (SAMPLE_REG) begin : g_sampled
         always_ff @(posedge clk) begin
            if (!rst_n) stat_q <= '0;
            else        stat_q <= stat_i;
         end
      end else begin : g_direct
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign stat_q     = stat_i;
      end
   endgenerate

   always_comb begin
      rword_o = '0;
      for (int w = 0; w < int'(NUM_WORDS); w++) begin
         if (idx_i == IDX_W'(w))
            rword_o = stat_q[w*BUS_W +: BUS_W];
      end
   end
endmodule

// File: rtl/masked_ctrl_bank.sv
module masked_ctrl_bank
   import mcb_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned RGN_SHIFT   = 8,
   parameter int unsigned NUM_FUNC    = 8,
   parameter int unsigned NUM_INV     = 32,
   parameter int unsigned NUM_STAT    = 64,
   parameter bit          STAT_SAMPLE = 1'b1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic                        rd_en,
   input  logic [ADDR_W-1:0]           addr,
   input  logic [31:0]                 wr_data,
   output logic [31:0]                 rd_data,
   input  logic [NUM_STAT-1:0]         stat_i,
   output logic [NUM_FUNC*FIELD_W-1:0] func_sel_o,
   output logic [NUM_INV-1:0]          inv_o
);
   localparam int unsigned IDX_W      = RGN_SHIFT - 2;
   localparam int unsigned FUNC_WORDS = (NUM_FUNC + 1) / 2;
   localparam int unsigned INV_WORDS  = NUM_INV / HALF_W;
   localparam int unsigned STAT_WORDS = NUM_STAT / BUS_W;

   generate
      if (NUM_INV == 0 || NUM_INV % HALF_W != 0) begin : g_bad_inv
         $error("NUM_INV must be a non-zero multiple of 16");
      end
      if (NUM_STAT == 0 || NUM_STAT % BUS_W != 0) begin : g_bad_stat
         $error("NUM_STAT must be a non-zero multiple of 32");
      end
      if (NUM_FUNC == 0) begin : g_bad_func
         $error("NUM_FUNC must be non-zero");
      end
      if (RGN_SHIFT < 3 || ADDR_W < RGN_SHIFT + 2) begin : g_bad_addr
         $error("ADDR_W must leave at least two region select bits above RGN_SHIFT");
      end
      if (FUNC_WORDS > 2**IDX_W || INV_WORDS > 2**IDX_W || STAT_WORDS > 2**IDX_W) begin : g_bad_fit
         $error("a region holds more words than RGN_SHIFT allows");
      end
   endgenerate

   region_e          rgn;
   logic [IDX_W-1:0] idx;
   logic [31:0]      func_word, inv_word, stat_word;
   logic             func_wr, inv_wr;

   mcb_addr_dec #(
      .ADDR_W(ADDR_W), .RGN_SHIFT(RGN_SHIFT),
      .FUNC_WORDS(FUNC_WORDS), .INV_WORDS(INV_WORDS), .STAT_WORDS(STAT_WORDS)
   ) u_dec (
      .addr_i(addr), .rgn_o(rgn), .idx_o(idx)
   );

   assign func_wr = wr_en && (rgn == RGN_FUNC);
   assign inv_wr  = wr_en && (rgn == RGN_INV);

   mcb_func_bank #(.NUM_FUNC(NUM_FUNC), .IDX_W(IDX_W)) u_func (
      .clk(clk), .rst_n(rst_n), .wr_i(func_wr), .idx_i(idx),
      .wdata_i(wr_data), .fields_o(func_sel_o), .rword_o(func_word)
   );

   mcb_mask_bank #(.NUM_BITS(NUM_INV), .IDX_W(IDX_W)) u_inv (
      .clk(clk), .rst_n(rst_n), .wr_i(inv_wr), .idx_i(idx),
      .wdata_i(wr_data), .bits_o(inv_o), .rword_o(inv_word)
   );

   mcb_stat_bank #(.NUM_BITS(NUM_STAT), .SAMPLE_REG(STAT_SAMPLE), .IDX_W(IDX_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .stat_i(stat_i), .idx_i(idx), .rword_o(stat_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_en) begin
         case (rgn)
            RGN_FUNC: rd_data <= func_word;
            RGN_INV:  rd_data <= inv_word;
            RGN_STAT: rd_data <= stat_word;
            default:  rd_data <= '0;
         endcase
      end
   end
endmodule

// File: rtl/mcb_checker.sv
module mcb_checker #(
   parameter int unsigned ADDR_W    = 12,
   parameter int unsigned RGN_SHIFT = 8,
   parameter int unsigned NUM_FUNC  = 8,
   parameter int unsigned NUM_INV   = 32,
   localparam int unsigned SEL_W    = ADDR_W - RGN_SHIFT,
   localparam int unsigned IDX_W    = RGN_SHIFT - 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  wr_en,
   input logic                  rd_en,
   input logic [ADDR_W-1:0]     addr,
   input logic [31:0]           wr_data,
   input logic [31:0]           rd_data,
   input logic [NUM_FUNC*7-1:0] func_sel_o,
   input logic [NUM_INV-1:0]    inv_o
);
   logic [SEL_W-1:0]      sel;
   logic [IDX_W-1:0]      word;
   logic [1:0]            unused_lsb;
   logic [NUM_FUNC*7-1:0] func_allow_d, func_allow_q;
   logic [NUM_INV-1:0]    inv_allow_d, inv_allow_q;

   assign sel        = addr[ADDR_W-1:RGN_SHIFT];
   assign word       = addr[RGN_SHIFT-1:2];
   assign unused_lsb = addr[1:0];

   always_comb begin
      func_allow_d = '0;
      inv_allow_d  = '0;
      for (int f = 0; f < int'(NUM_FUNC); f++)
         for (int k = 0; k < 7; k++)
            func_allow_d[f*7+k] = wr_en && sel == SEL_W'(0) && word == IDX_W'(f/2)
                                  && wr_data[16 + (f%2)*8 + k];
      for (int n = 0; n < int'(NUM_INV); n++)
         inv_allow_d[n] = wr_en && sel == SEL_W'(1) && word == IDX_W'(n/16)
                          && wr_data[16 + n%16];
   end

   always_ff @(posedge clk) begin
      func_allow_q <= func_allow_d;
      inv_allow_q  <= inv_allow_d;
   end

   assert_reset_clear_R8: assert property (@(posedge clk)
      !rst_n |=> (func_sel_o == '0 && inv_o == '0 && rd_data == '0));

   assert_inv_unmasked_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((inv_o ^ $past(inv_o)) & ~inv_allow_q) == '0));

   assert_func_unmasked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((func_sel_o ^ $past(func_sel_o)) & ~func_allow_q) == '0));

   assert_zero_mask_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data[31:16] == 16'h0) |=> ($stable(func_sel_o) && $stable(inv_o)));

   assert_status_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel == SEL_W'(2)) |=> ($stable(func_sel_o) && $stable(inv_o)));

   assert_unmapped_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sel > SEL_W'(2)) |=> ($stable(func_sel_o) && $stable(inv_o)));

   assert_read_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

   assert_func_read_gaps_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && sel == SEL_W'(0)) |=> (rd_data[31:16] == 16'h0 && !rd_data[15] && !rd_data[7]));

   assert_inv_read_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && sel == SEL_W'(1)) |=> (rd_data[31:16] == 16'h0));

   assert_unmapped_read_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && sel > SEL_W'(2)) |=> (rd_data == 32'h0));
endmodule

bind masked_ctrl_bank mcb_checker #(
   .ADDR_W(ADDR_W), .RGN_SHIFT(RGN_SHIFT), .NUM_FUNC(NUM_FUNC), .NUM_INV(NUM_INV)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .wr_data(wr_data), .rd_data(rd_data), .func_sel_o(func_sel_o), .inv_o(inv_o)
);

// File: tb/masked_ctrl_bank_tb.sv
module masked_ctrl_bank_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NF = 8;
   localparam int NI = 32;
   localparam int NS = 64;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [11:0]   addr = '0;
   logic [31:0]   wr_data = '0;
   logic [31:0]   rd_data;
   logic [NS-1:0] stat_vec = '0;
   logic [NF*7-1:0] func_sel_o;
   logic [NI-1:0]   inv_o;

   logic [NF*7-1:0] func_m = '0;
   logic [NI-1:0]   inv_m = '0;
   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   masked_ctrl_bank u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .stat_i(stat_vec),
      .func_sel_o(func_sel_o), .inv_o(inv_o)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_read(input logic [11:0] a);
      logic [3:0] s = a[11:8];
      int w = int'(a[7:2]);
      if (s == 0 && w < 4)
         return {16'h0, 1'b0, func_m[(2*w+1)*7 +: 7], 1'b0, func_m[2*w*7 +: 7]};
      if (s == 1 && w < 2) return {16'h0, inv_m[w*16 +: 16]};
      if (s == 2 && w < 2) return stat_vec[w*32 +: 32];
      return 32'h0;
   endfunction

   task automatic model_write(input logic [11:0] a, input logic [31:0] d);
      logic [3:0] s = a[11:8];
      int w = int'(a[7:2]);
      if (s == 0 && w < 4) begin
         for (int h = 0; h < 2; h++)
            for (int k = 0; k < 7; k++)
               if (d[16 + h*8 + k]) func_m[(2*w+h)*7 + k] = d[h*8 + k];
      end else if (s == 1 && w < 2) begin
         for (int k = 0; k < 16; k++)
            if (d[16+k]) inv_m[w*16 + k] = d[k];
      end
   endtask

   task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      model_write(a, d);
   endtask

   task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rd_data;
   endtask

   task automatic read_chk(input string req, input logic [11:0] a);
      logic [31:0] exp = exp_read(a);
      logic [31:0] got;
      bus_read(a, got);
      chk(req, {32'h0, got}, {32'h0, exp});
   endtask

   task automatic out_chk(input string req);
      chk({req, " func_sel_o"}, {8'h0, func_sel_o}, {8'h0, func_m});
      chk({req, " inv_o"}, {32'h0, inv_o}, {32'h0, inv_m});
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
      func_m = '0; inv_m = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [31:0] hold, got;
      void'($urandom(32'h1d3a5c07));
      @(negedge clk); @(negedge clk);
      // R8: reset state
      chk("R8 reset func", {8'h0, func_sel_o}, 64'h0);
      chk("R8 reset inv", {32'h0, inv_o}, 64'h0);
      chk("R8 reset rd_data", {32'h0, rd_data}, 64'h0);
      rst_n = 1'b1;

      // R3 R11: fully enabled write of both selectors in word 0
      bus_write(12'h000, 32'h7F7F_1234);
      out_chk("R11 full write");
      chk("R3 field f0", {57'h0, func_sel_o[6:0]}, 64'h34);
      chk("R3 field f1", {57'h0, func_sel_o[13:7]}, 64'h12);
      read_chk("R4 func readback", 12'h000);
      // R1 R3: partial enable, odd field only, in word 3 (f6, f7)
      bus_write(12'h00C, 32'h0500_7F7F);
      out_chk("R3 partial odd field");
      read_chk("R4 func word3", 12'h00C);
      // R2: zero enable half
      bus_write(12'h000, 32'h0000_FFFF);
      out_chk("R2 zero enable");
      // R5 R1: invert pins in word 1 (pins 16..31)
      bus_write(12'h104, 32'hF0F0_FFFF);
      out_chk("R5 invert word1");
      chk("R5 inv_o[20]", {63'h0, inv_o[20]}, 64'h1);
      read_chk("R5 invert readback", 12'h104);
      // R6: status sampling, pin 40 is word 1 bit 8
      stat_vec = 64'hA5A5_0100_DEAD_BEEF;
      @(negedge clk); @(negedge clk);
      read_chk("R6 status word0", 12'h200);
      read_chk("R6 status word1", 12'h204);
      // R7: write to status region
      bus_write(12'h200, 32'hFFFF_FFFF);
      out_chk("R7 status write");
      read_chk("R7 status unchanged", 12'h200);
      // R10: unmapped reads and writes
      bus_write(12'h300, 32'hFFFF_FFFF);
      bus_write(12'h010, 32'hFFFF_FFFF);
      out_chk("R10 unmapped write");
      read_chk("R10 unmapped read", 12'h300);
      read_chk("R10 past last func word", 12'h010);
      // R9: hold while rd_en low
      bus_read(12'h000, hold);
      bus_write(12'h000, 32'h7F00_0055);
      @(negedge clk);
      chk("R9 hold", {32'h0, rd_data}, {32'h0, hold});
      // R9: read and write in the same cycle returns the old value
      hold = exp_read(12'h100);
      @(negedge clk);
      rd_en = 1'b1; wr_en = 1'b1; addr = 12'h100; wr_data = 32'hFFFF_1357;
      @(negedge clk);
      rd_en = 1'b0; wr_en = 1'b0;
      model_write(12'h100, 32'hFFFF_1357);
      chk("R9 read before write", {32'h0, rd_data}, {32'h0, hold});
      out_chk("R1 same cycle write");

      // Random traffic
      for (int i = 0; i < 400; i++) begin
         logic [3:0]  s = 4'($urandom_range(0, 4));
         logic [5:0]  w = 6'($urandom_range(0, 5));
         logic [11:0] a = {s, w, 2'($urandom)};
         logic [31:0] d = $urandom;
         if ($urandom_range(0, 3) == 0) d[31:16] = 16'h0;
         if ($urandom_range(0, 5) == 0) stat_vec = {$urandom, $urandom};
         if ($urandom_range(0, 1) == 0) begin
            bus_write(a, d);
            out_chk("R1 random write");
         end else begin
            @(negedge clk);
            read_chk("R6 random read", a);
         end
      end

      // R8: reset during operation
      do_reset();
      @(negedge clk);
      chk("R8 mid-run func", {8'h0, func_sel_o}, 64'h0);
      chk("R8 mid-run inv", {32'h0, inv_o}, 64'h0);
      bus_read(12'h000, got);
      chk("R8 mid-run read", {32'h0, got}, 64'h0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule